// File: doc/BRIEF.md
# USB Root Port Control Sequencer

This block holds the status and control word for one downstream port of a full/low-speed host root hub. Software reads and writes a 16-bit word. The port side supplies connect, low-speed and overcurrent levels and a remote-wakeup pulse. The block drives three request lines toward the line signalling logic: bus reset, suspend and resume.

The block times the bus reset and resume sequences itself, counting a free-running millisecond tick. When a reset ends, the port is enabled and the change flags that the reset caused are cleaned up. When a resume ends, the suspend and resume flags are dropped. The resume flag then keeps reading set for a short tail while the end-of-packet that closes resume signalling goes out. A resume request on a disabled port is refused. Starting a reset, or disabling the port, cuts off any resume in progress.

Word layout, least significant bit first:

| Bit | Field | Access |
|-----|-------|--------|
| 0 | connected | read-only |
| 1 | connect change | write 1 to clear |
| 2 | enabled | read/write |
| 3 | enable change | write 1 to clear |
| 4 | low-speed device | read-only |
| 5 | overcurrent | read-only |
| 6 | overcurrent change | write 1 to clear |
| 7 | resume | read/write |
| 8 | reset | write 1 to start |
| 9 | suspend | read/write |
| 15:10 | reserved | read as zero |

Top module: `usb_rport_seq`

## Requirements
- R1: After `rst_n` is released with all port inputs low, `rd_data` is 0x0000 and `drive_reset`, `drive_suspend` and `drive_resume` are all 0.
- R2: The read-only fields follow the port inputs one clock later: bit 0 follows `dev_conn`, bit 4 follows `dev_ls` and bit 5 follows `dev_oc`.
- R3: Any edge on `dev_conn` sets bit 1 (connect change). Any edge on `dev_oc` sets bit 6 (overcurrent change). If such an edge coincides with a clearing write, the set wins.
- R4: Bits 1, 3 and 6 are cleared by a write with a 1 in that position. A write with a 0 in that position leaves the bit unchanged.
- R5: Bits 15:10 always read 0, whatever value is written to them.
- R6: A write that sets bit 7 while bit 2 reads 0 is ignored, and bit 7 stays 0.
- R7: Writing 1 to bit 8 starts a reset. Bit 8 and `drive_reset` then stay 1 for RESET_MS ticks of `ms_tick`. On the RESET_MS-th tick they drop, bit 2 becomes 1, and bits 1 and 3 become 0.
- R8: If the port was enabled when a reset starts, bit 3 is set and bit 2 is cleared.
- R9: Writing 1 to bit 7 on an enabled port starts a resume. On the RESUME_MS-th tick after that, bits 9 and 7 are cleared together.
- R10: After bit 7 is cleared, whether by the timer or by a write, bit 7 and `drive_resume` keep reading 1 for EOP_CYC more clock cycles.
- R11: Starting a reset, or writing 0 to bit 2 while it reads 1, clears bit 9 and ends any resume at once.
- R12: A `dev_wakeup` pulse on a port that is enabled and suspended sets bit 7 and starts the same RESUME_MS timer as a host request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Current register value |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| dev_conn | input | 1 | Device connected level |
| dev_ls | input | 1 | Low-speed device level |
| dev_oc | input | 1 | Overcurrent level |
| dev_wakeup | input | 1 | Remote wakeup pulse from the device |
| drive_reset | output | 1 | Request bus reset signalling |
| drive_suspend | output | 1 | Request suspend (idle) on the port |
| drive_resume | output | 1 | Request resume signalling, including the closing end-of-packet |

## Verification
The hardest situations to reach are the ones where a timed sequence is cut short. Examples are a reset or a port disable that lands while resume signalling is running, and the end-of-packet tail that runs on after a resume finishes.

The stimulus builds these states step by step. It enables the port through a full reset, suspends it, starts a resume (either from a host write or from a wakeup pulse), and then interrupts the resume or lets it run to completion. The reduced tick counts keep every window short enough to sample each boundary cycle exactly.

Random write values and random input edges stress the change-bit rules while the port is disabled. A disabled port is also the state in which resume requests must be refused.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
    localparam int B_CONN = 0;
    localparam int B_CCHG = 1;
    localparam int B_EN   = 2;
    localparam int B_ECHG = 3;
    localparam int B_LS   = 4;
    localparam int B_OC   = 5;
    localparam int B_OCHG = 6;
    localparam int B_RSM  = 7;
    localparam int B_RST  = 8;
    localparam int B_SUSP = 9;

    typedef struct packed {
        logic conn_chg;
        logic enable;
        logic en_chg;
        logic ls;
        logic oc_chg;
        logic resume;
        logic reset;
        logic suspend;
    } port_regs_t;
endpackage

// File: rtl/usbp_edge.sv
module usbp_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] changed
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl_in[i];
        end
        assign lvl_q[i]   = prev_q;
        assign changed[i] = lvl_in[i] ^ prev_q;
    end
endmodule

// File: rtl/usbp_ms_timer.sv
module usbp_ms_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done,
    output logic         busy
);
    logic [W-1:0] cnt_q, cnt_d;
    logic         run_q, run_d;

    assign done = run_q && tick && (cnt_q == limit - W'(1));
    assign busy = run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start) begin
            run_d = 1'b1;
            cnt_d = '0;
        end else if (abort || done) begin
            run_d = 1'b0;
        end else if (run_q && tick) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/usbp_eop_tail.sv
module usbp_eop_tail #(
    parameter int EOP_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(EOP_CYC + 1);
    logic [CW-1:0] cnt_q, cnt_d;

    assign active = (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (start)       cnt_d = CW'(EOP_CYC);
        else if (active) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/usb_rport_seq.sv
module usb_rport_seq
    import usbp_pkg::*;
#(
    parameter int RESET_MS  = 50,
    parameter int RESUME_MS = 20,
    parameter int EOP_CYC   = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        ms_tick,
    input  logic        dev_conn,
    input  logic        dev_ls,
    input  logic        dev_oc,
    input  logic        dev_wakeup,
    output logic        drive_reset,
    output logic        drive_suspend,
    output logic        drive_resume
);
    localparam int MAX_MS = (RESET_MS > RESUME_MS) ? RESET_MS : RESUME_MS;
    localparam int TW     = $clog2(MAX_MS + 1);

    port_regs_t s_q, s_d;
    logic [1:0]    lvl_q, chg;
    logic          tmr_start, tmr_abort, tmr_done, tmr_busy;
    logic          tail_start, tail_act;
    logic [TW-1:0] tmr_limit;
    logic          rsm_rd;
    logic          wr_unused;

    assign wr_unused = ^{wr_data[15:10], wr_data[B_OC], wr_data[B_LS], wr_data[B_CONN], tmr_busy};

    usbp_edge #(.N(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  ({dev_oc, dev_conn}),
        .lvl_q   (lvl_q),
        .changed (chg)
    );

    assign tmr_limit = s_q.reset ? TW'(RESET_MS) : TW'(RESUME_MS);

    usbp_ms_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .abort (tmr_abort),
        .tick  (ms_tick),
        .limit (tmr_limit),
        .done  (tmr_done),
        .busy  (tmr_busy)
    );

    usbp_eop_tail #(.EOP_CYC(EOP_CYC)) u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tail_start),
        .active (tail_act)
    );

    always_comb begin
        s_d        = s_q;
        tmr_start  = 1'b0;
        tmr_abort  = 1'b0;
        tail_start = 1'b0;
        s_d.ls     = dev_ls;

        if (wr_en) begin
            // write-1-to-clear change flags
            if (wr_data[B_CCHG]) s_d.conn_chg = 1'b0;
            if (wr_data[B_ECHG]) s_d.en_chg   = 1'b0;
            if (wr_data[B_OCHG]) s_d.oc_chg   = 1'b0;
            if (!s_q.reset) begin
                if (wr_data[B_RST]) begin
                    s_d.reset   = 1'b1;
                    tmr_start   = 1'b1;
                    if (s_q.enable) s_d.en_chg = 1'b1;
                    s_d.enable  = 1'b0;
                    s_d.suspend = 1'b0;
                    s_d.resume  = 1'b0;
                    tail_start  = s_q.resume;
                end else if (s_q.enable && !wr_data[B_EN]) begin
                    s_d.enable  = 1'b0;
                    s_d.suspend = 1'b0;
                    s_d.resume  = 1'b0;
                    tail_start  = s_q.resume;
                    tmr_abort   = s_q.resume;
                end else begin
                    s_d.enable  = wr_data[B_EN];
                    s_d.suspend = wr_data[B_SUSP];
                    if (wr_data[B_RSM] && !s_q.resume && s_q.enable) begin
                        s_d.resume = 1'b1;
                        tmr_start  = 1'b1;
                    end else if (!wr_data[B_RSM] && s_q.resume) begin
                        s_d.resume = 1'b0;
                        tmr_abort  = 1'b1;
                        tail_start = 1'b1;
                    end
                end
            end
        end else if (dev_wakeup && s_q.enable && s_q.suspend && !s_q.resume && !s_q.reset) begin
            s_d.resume = 1'b1;
            tmr_start  = 1'b1;
        end

        if (chg[0]) s_d.conn_chg = 1'b1;
        if (chg[1]) s_d.oc_chg   = 1'b1;

        if (tmr_done) begin
            if (s_q.reset) begin
                s_d.reset    = 1'b0;
                s_d.enable   = 1'b1;
                s_d.conn_chg = 1'b0;
                s_d.en_chg   = 1'b0;
            end else if (s_q.resume) begin
                s_d.resume  = 1'b0;
                s_d.suspend = 1'b0;
                tail_start  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsm_rd = s_q.resume | tail_act;

    always_comb begin
        rd_data         = '0;
        rd_data[B_CONN] = lvl_q[0];
        rd_data[B_CCHG] = s_q.conn_chg;
        rd_data[B_EN]   = s_q.enable;
        rd_data[B_ECHG] = s_q.en_chg;
        rd_data[B_LS]   = s_q.ls;
        rd_data[B_OC]   = lvl_q[1];
        rd_data[B_OCHG] = s_q.oc_chg;
        rd_data[B_RSM]  = rsm_rd;
        rd_data[B_RST]  = s_q.reset;
        rd_data[B_SUSP] = s_q.suspend;
    end

    assign drive_reset   = s_q.reset;
    assign drive_suspend = s_q.suspend & ~rsm_rd;
    assign drive_resume  = rsm_rd;
endmodule

// File: rtl/usb_rport_seq_chk.sv
module usb_rport_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        dev_conn,
    input logic        drive_reset,
    input logic        drive_suspend
);
    logic chk_unused;
    assign chk_unused = ^{wr_data[15:8], wr_data[6:2], wr_data[0], rd_data[15:10], rd_data[8], rd_data[6:4]};

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && (dev_conn == rd_data[0])) |=> !rd_data[1]);

    p_w0_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[1] && rd_data[1] && !drive_reset) |=> rd_data[1]);

    p_no_resume_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && !rd_data[2] && !rd_data[7]) |=> !rd_data[7]);

    p_reset_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_reset) |-> (rd_data[2] && !rd_data[1] && !rd_data[3]));

    p_reset_en_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drive_reset) && $past(rd_data[2])) |-> (rd_data[3] && !rd_data[2]));

    p_reset_no_suspend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drive_reset |-> (!rd_data[9] && !drive_suspend));
endmodule

bind usb_rport_seq usb_rport_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .dev_conn      (dev_conn),
    .drive_reset   (drive_reset),
    .drive_suspend (drive_suspend)
);

// File: tb/usb_rport_seq_tb.sv
`timescale 1ns/1ps
module usb_rport_seq_tb;
    localparam int RMS = 5;
    localparam int SMS = 3;
    localparam int EOP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        ms_tick = 1'b0;
    logic        dev_conn = 1'b0, dev_ls = 1'b0, dev_oc = 1'b0, dev_wakeup = 1'b0;
    logic        drive_reset, drive_suspend, drive_resume;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    usb_rport_seq #(.RESET_MS(RMS), .RESUME_MS(SMS), .EOP_CYC(EOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ms_tick(ms_tick), .dev_conn(dev_conn), .dev_ls(dev_ls), .dev_oc(dev_oc),
        .dev_wakeup(dev_wakeup), .drive_reset(drive_reset), .drive_suspend(drive_suspend),
        .drive_resume(drive_resume)
    );

    function automatic logic [15:0] exp_word(input logic conn, cc, en, ec, ls, oc, occ, rsm, rst, susp);
        return {6'b0, susp, rst, rsm, occ, oc, ls, ec, en, cc, conn};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic m_conn, m_cc, m_ec, m_ls, m_oc, m_occ;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 word", rd_data, 16'h0000);
        check("R1 drives", {13'b0, drive_reset, drive_suspend, drive_resume}, 16'h0000);

        // random phase: disabled port, random edges and W1C writes (R2 R3 R4 R5 R6)
        m_conn = 0; m_cc = 0; m_ec = 0; m_ls = 0; m_oc = 0; m_occ = 0;
        for (int i = 0; i < 300; i++) begin
            logic nc, no, nl, we;
            logic [15:0] d;
            nc = 1'($urandom); no = 1'($urandom); nl = 1'($urandom); we = 1'($urandom);
            d = 16'($urandom) & 16'hFCCA;
            dev_conn = nc; dev_oc = no; dev_ls = nl;
            wr_en = we; wr_data = d;
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0;
            if (we && d[1]) m_cc = 0;
            if (we && d[3]) m_ec = 0;
            if (we && d[6]) m_occ = 0;
            if (nc != m_conn) m_cc = 1;
            if (no != m_oc) m_occ = 1;
            m_conn = nc; m_oc = no; m_ls = nl;
            check("R2 R3 R4 R5 R6 random", rd_data,
                  exp_word(m_conn, m_cc, 0, m_ec, m_ls, m_oc, m_occ, 0, 0, 0));
        end

        // directed: connected full-speed device, clear all change flags
        dev_conn = 1; dev_oc = 0; dev_ls = 0;
        @(negedge clk);
        wr(16'hFC4A);
        check("R4 R5 clear", rd_data, 16'h0001);
        // write zero leaves flags: raise conn change first
        dev_conn = 0; @(negedge clk); dev_conn = 1; @(negedge clk);
        wr(16'h0000);
        check("R4 write0 keeps", rd_data, 16'h0003);
        wr(16'h0002);
        check("R4 write1 clears", rd_data, 16'h0001);

        // R6 refused resume on disabled port
        wr(16'h0080);
        check("R6 refused", rd_data, 16'h0001);

        // R7 reset on disabled port
        wr(16'h0100);
        check("R7 reset on", rd_data, 16'h0101);
        check("R7 drive_reset", {15'b0, drive_reset}, 16'h0001);
        wr(16'h0004);
        check("R7 write during reset", rd_data, 16'h0101);
        for (int k = 0; k < RMS - 1; k++) tick();
        check("R7 still reset", rd_data, 16'h0101);
        tick();
        check("R7 release", rd_data, 16'h0005);

        // R8 reset on enabled port
        wr(16'h0104);
        check("R8 en change", rd_data, 16'h0109);
        for (int k = 0; k < RMS; k++) tick();
        check("R8 R7 release", rd_data, 16'h0005);

        // R9 R10 host resume
        wr(16'h0204);
        check("R9 suspend", {rd_data[15:1], drive_suspend}, 16'h0205);
        wr(16'h0284);
        check("R9 resume on", {rd_data[15:1], drive_resume}, 16'h0285);
        for (int k = 0; k < SMS - 1; k++) tick();
        check("R9 still resume", rd_data, 16'h0285);
        tick();
        check("R9 R10 end tail", rd_data, 16'h0085);
        repeat (EOP - 1) @(negedge clk);
        check("R10 tail last", {rd_data[15:1], drive_resume}, 16'h0085);
        @(negedge clk);
        check("R10 tail gone", {rd_data[15:1], drive_resume}, 16'h0004);

        // R12 remote wakeup
        wr(16'h0204);
        dev_wakeup = 1; @(negedge clk); dev_wakeup = 0;
        check("R12 wakeup", rd_data, 16'h0285);
        for (int k = 0; k < SMS; k++) tick();
        check("R12 timed end", rd_data, 16'h0085);
        repeat (EOP + 1) @(negedge clk);

        // R11 disable ends resume
        wr(16'h0204);
        wr(16'h0284);
        wr(16'h0000);
        check("R11 disable", {rd_data[15:1], drive_suspend}, 16'h0080);
        repeat (EOP + 1) @(negedge clk);
        check("R11 idle", rd_data, 16'h0001);

        // R11 reset ends resume
        wr(16'h0004);
        wr(16'h0204);
        wr(16'h0284);
        wr(16'h0100);
        check("R11 reset", {rd_data[15:1], drive_suspend}, 16'h0188);
        for (int k = 0; k < RMS; k++) tick();
        check("R11 R7 after", rd_data, 16'h0005);

        // R3 overcurrent edge
        dev_oc = 1; @(negedge clk);
        check("R3 oc edge", rd_data, 16'h0065);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule